// File: doc/BRIEF.md
# Multiplexed-Address Dynamic RAM Controller

This block sits between a simple host request port and a single 64K x 1 dynamic RAM whose row and column addresses share one 8-bit address bus. The host raises a request with a 16-bit address, a direction flag and one write bit. The controller opens the row, switches the bus to the column, strobes the column and returns a one-cycle done pulse. For reads, the sampled data bit is returned with that pulse.

Once an access finishes, the row stays open. A later request to the same row reuses it and toggles only the column strobe. A request to another row first closes the page. A refresh timer runs in the background. When it expires, the controller closes any open page and runs a row-strobe-only cycle on the next of 128 rows. Any host request is held back until that cycle finishes. All timing intervals are counted in clock cycles and set by parameters.

Top module: `dram_mux_ctl`

## Requirements
- R1: The row half of the host address is `host_addr[15:8]` and is on `dram_ma` when `dram_ras_n` falls. The column half is `host_addr[7:0]` and is on `dram_ma` when `dram_cas_n` falls.
- R2: `dram_ma` is unchanged in the cycle before each `dram_ras_n` fall and before each `dram_cas_n` fall. `dram_cas_n` is low only while `dram_ras_n` is low. The first column strobe after a row opens falls no sooner than T_RCD cycles after `dram_ras_n` fell, and never before T_RAH cycles have passed.
- R3: `host_we`=1 requests a write and `host_we`=0 a read. For a write, `dram_we_n` is low and `dram_din` holds the write bit in the cycle before `dram_cas_n` falls, and both stay unchanged while the column strobe is low. For a read, `dram_we_n` stays high.
- R4: `dram_cas_n` stays low for exactly T_CAS cycles. A read samples `dram_dout` at the end of the last of those cycles and presents the bit on `host_rdata` while `host_done` is high.
- R5: Each request yields exactly one one-cycle `host_done` pulse. The host holds `host_req`, `host_we`, `host_addr` and `host_wdata` steady until it sees `host_done`, and drops `host_req` in that same cycle.
- R6: A request whose row equals the open row causes no new `dram_ras_n` fall. Only a new column strobe is issued.
- R7: A request for a different row raises `dram_ras_n`. The strobe stays high for at least T_RP cycles before the new row opens.
- R8: A refresh becomes due every REF_PERIOD cycles. A refresh is a row-strobe cycle with `dram_cas_n` held high throughout, and `dram_ras_n` stays low for at least T_RAS_REF cycles.
- R9: A 7-bit refresh row counter goes onto `dram_ma[6:0]` with `dram_ma[7]`=0. It advances by one, modulo 128, after each refresh, so every 128 refreshes cover all rows.
- R10: A due refresh closes an open page (with T_RP precharge) ahead of any host access. A request that arrives during a refresh waits and then completes with correct data.
- R11: During and straight after reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `host_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, held until done |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Word address, row in upper byte |
| host_wdata | input | 1 | Write data bit |
| host_rdata | output | 1 | Read data bit, valid with done |
| host_done | output | 1 | One-cycle completion pulse |
| dram_ma | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data into the RAM |
| dram_dout | input | 1 | Data out of the RAM |

## Verification
The bench builds the controller with T_RAH=1, T_RCD=3, T_RP=2, T_CAS=2, T_RAS_REF=4 and REF_PERIOD=64. These short settings let one run cover every one of the 256 rows with both a page-opening access and a page hit. The run also includes a full 256-column burst in one row and more than 128 refreshes, so the refresh row counter wraps. Because refreshes fall due about every 64 cycles, many host requests collide with a pending or running refresh. The RAM model returns inverted data until T_CAS strobe cycles have passed, so a read that samples early is caught.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  localparam int ADDR_W    = 16;
  localparam int HALF_W    = ADDR_W / 2;
  localparam int REF_ROW_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_RAH, ST_COL, ST_CAS, ST_DONE,
    ST_OPEN, ST_PRE, ST_REF_ROW, ST_REF_RAS, ST_REF_PRE
  } ctl_state_e;

  function automatic logic [HALF_W-1:0] row_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:HALF_W];
  endfunction

  function automatic logic [HALF_W-1:0] col_of(input logic [ADDR_W-1:0] a);
    return a[HALF_W-1:0];
  endfunction

  // cycles the column sits on the bus before the strobe on a fresh row
  function automatic int col_setup(input int t_rah, input int t_rcd);
    return (t_rcd - t_rah > 1) ? (t_rcd - t_rah) : 1;
  endfunction

  function automatic logic [HALF_W-1:0] ref_bus(input logic [REF_ROW_W-1:0] r);
    return {{(HALF_W-REF_ROW_W){1'b0}}, r};
  endfunction
endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dram_ref_sched.sv
module dram_ref_sched #(
  parameter int REF_PERIOD = 1500,
  parameter int ROW_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic             step,
  output logic             pending,
  output logic [ROW_W-1:0] row
);
  localparam int PER_W = $clog2(REF_PERIOD + 1);
  logic [PER_W-1:0] tick_q;
  logic             wrap;

  assign wrap = (tick_q == PER_W'(REF_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q  <= '0;
      pending <= 1'b0;
      row     <= '0;
    end else begin
      tick_q <= wrap ? '0 : tick_q + 1'b1;
      if (wrap)     pending <= 1'b1;
      else if (ack) pending <= 1'b0;
      if (step)     row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/dram_mux_ctl.sv
module dram_mux_ctl
  import dram_ctl_pkg::*;
#(
  parameter int T_RAH      = 1,
  parameter int T_RCD      = 3,
  parameter int T_RP       = 2,
  parameter int T_CAS      = 2,
  parameter int T_RAS_REF  = 4,
  parameter int REF_PERIOD = 1500,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wdata,
  output logic              host_rdata,
  output logic              host_done,
  output logic [HALF_W-1:0] dram_ma,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_din,
  input  logic              dram_dout
);
  localparam int COL_CYC = col_setup(T_RAH, T_RCD);

  ctl_state_e state_q, state_d;
  logic [HALF_W-1:0]    row_q, col_q;
  logic                 wr_q, wd_q, rdata_q;
  logic                 tmr_load, tmr_zero;
  logic [CNT_W-1:0]     tmr_val;
  logic                 take_new, take_hit;
  logic                 ref_pend, ref_ack, ref_step;
  logic [REF_ROW_W-1:0] ref_row;
  logic                 ref_busy, page_hit, rd_sample;

  dram_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  dram_ref_sched #(.REF_PERIOD(REF_PERIOD), .ROW_W(REF_ROW_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .ack(ref_ack), .step(ref_step),
    .pending(ref_pend), .row(ref_row)
  );

  assign page_hit  = (row_of(host_addr) == row_q);
  assign rd_sample = (state_q == ST_CAS) && tmr_zero && !wr_q;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take_new = 1'b0;
    take_hit = 1'b0;
    ref_ack  = 1'b0;
    ref_step = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_pend) begin
          state_d = ST_REF_ROW;
          ref_ack = 1'b1;
        end else if (host_req) begin
          state_d  = ST_ROW;
          take_new = 1'b1;
        end
      end
      ST_ROW: begin
        state_d  = ST_RAH;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RAH - 1);
      end
      ST_RAH: if (tmr_zero) begin
        state_d  = ST_COL;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(COL_CYC - 1);
      end
      ST_COL: if (tmr_zero) begin
        state_d  = ST_CAS;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_CAS - 1);
      end
      ST_CAS:  if (tmr_zero) state_d = ST_DONE;
      ST_DONE: state_d = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend || (host_req && !page_hit)) begin
          state_d  = ST_PRE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(T_RP - 1);
        end else if (host_req) begin
          state_d  = ST_COL;
          take_hit = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = '0;
        end
      end
      ST_PRE: if (tmr_zero) state_d = ST_IDLE;
      ST_REF_ROW: begin
        state_d  = ST_REF_RAS;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RAS_REF - 1);
      end
      ST_REF_RAS: if (tmr_zero) begin
        state_d  = ST_REF_PRE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(T_RP - 1);
      end
      ST_REF_PRE: if (tmr_zero) begin
        state_d  = ST_IDLE;
        ref_step = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      wd_q    <= 1'b0;
      rdata_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take_new) row_q <= row_of(host_addr);
      if (take_new || take_hit) begin
        col_q <= col_of(host_addr);
        wr_q  <= host_we;
        wd_q  <= host_wdata;
      end
      if (rd_sample) rdata_q <= dram_dout;
    end
  end

  assign ref_busy = (state_q == ST_REF_ROW) || (state_q == ST_REF_RAS) ||
                    (state_q == ST_REF_PRE);

  always_comb begin
    dram_ras_n = 1'b1;
    dram_cas_n = 1'b1;
    dram_we_n  = 1'b1;
    dram_ma    = row_q;
    unique case (state_q)
      ST_RAH:     dram_ras_n = 1'b0;
      ST_COL, ST_DONE, ST_OPEN: begin
        dram_ras_n = 1'b0;
        dram_ma    = col_q;
        dram_we_n  = !(wr_q && (state_q != ST_OPEN));
      end
      ST_CAS: begin
        dram_ras_n = 1'b0;
        dram_cas_n = 1'b0;
        dram_ma    = col_q;
        dram_we_n  = !wr_q;
      end
      ST_REF_ROW: dram_ma = ref_bus(ref_row);
      ST_REF_RAS: begin
        dram_ras_n = 1'b0;
        dram_ma    = ref_bus(ref_row);
      end
      default: ;
    endcase
  end

  assign dram_din   = wd_q;
  assign host_done  = (state_q == ST_DONE);
  assign host_rdata = rdata_q;
endmodule

// File: rtl/dram_mux_ctl_chk.sv
module dram_mux_ctl_chk
  import dram_ctl_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ras_n,
  input logic                 cas_n,
  input logic                 we_n,
  input logic                 din,
  input logic [HALF_W-1:0]    ma,
  input logic                 done,
  input logic                 ref_busy,
  input logic                 ref_step,
  input logic [REF_ROW_W-1:0] ref_row
);
  p_cas_in_ras_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);

  p_row_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(ma));

  p_col_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ma));

  p_early_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($stable(we_n) && $stable(din)));

  p_write_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && !we_n) |=> (!we_n && $stable(din)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_ref_no_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> cas_n);

  p_ref_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ref_busy |-> !done);

  p_ref_top_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_busy && !ras_n) |-> !ma[HALF_W-1]);

  p_ref_row_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_step |=> (ref_row == REF_ROW_W'($past(ref_row) + 1'b1)));
endmodule

bind dram_mux_ctl dram_mux_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .din(dram_din), .ma(dram_ma), .done(host_done),
  .ref_busy(ref_busy), .ref_step(ref_step), .ref_row(ref_row)
);

// File: tb/dram_mux_ctl_bench.sv
module dram_mux_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int T_RAH = 1, T_RCD = 3, T_RP = 2, T_CAS = 2, T_RAS_REF = 4;
  localparam int REF_PERIOD = 64;
  localparam int SLACK = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0, host_wdata = 1'b0;
  logic [15:0] host_addr = '0;
  logic host_rdata, host_done;
  logic [7:0] dram_ma;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_mux_ctl #(.T_RAH(T_RAH), .T_RCD(T_RCD), .T_RP(T_RP), .T_CAS(T_CAS),
                 .T_RAS_REF(T_RAS_REF), .REF_PERIOD(REF_PERIOD)) u_dram_mux_ctl (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_done(host_done), .dram_ma(dram_ma), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_din(dram_din),
    .dram_dout(dram_dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pat(input logic [15:0] a, input logic [15:0] seed);
    return ^(a ^ (a >> 5) ^ seed);
  endfunction

  // ---------------- RAM model and port monitor ----------------
  bit mem [int];
  logic [7:0] open_row = '0;
  logic prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_din = 1'b0;
  logic [7:0] prev_ma = '0;
  int lo_cnt = 0, hi_cnt = 0, cas_t = 0, cyc = 0;
  bit had_cas = 0;
  int ras_falls = 0, ref_cnt = 0, last_ref_cyc = 0;
  logic [6:0] exp_ref_row = '0;
  logic [15:0] last_key = '0;
  logic last_wr = 1'b0;

  function automatic logic rd_mem(input logic [15:0] k);
    return mem.exists(int'(k)) ? mem[int'(k)] : 1'b0;
  endfunction

  assign dram_dout = (!dram_cas_n && cas_t >= T_CAS) ? rd_mem({open_row, dram_ma})
                                                     : ~rd_mem({open_row, dram_ma});

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      cas_t = dram_cas_n ? 0 : cas_t + 1;
      if (prev_ras && !dram_ras_n) begin
        chk(dram_ma == prev_ma, "R2 row stable at RAS fall", dram_ma, prev_ma);
        chk(hi_cnt + 1 >= T_RP, "R7 precharge length", hi_cnt + 1, T_RP);
        open_row = dram_ma;
        had_cas  = 0;
        lo_cnt   = 0;
        ras_falls++;
      end else if (!dram_ras_n) lo_cnt++;
      if (!prev_ras && dram_ras_n) begin
        hi_cnt = 0;
        if (!had_cas) begin
          chk(open_row[7] == 1'b0, "R9 refresh A7 low", open_row[7], 0);
          chk(open_row[6:0] == exp_ref_row, "R9 refresh row order", open_row[6:0], exp_ref_row);
          chk(lo_cnt + 1 >= T_RAS_REF, "R8 refresh strobe length", lo_cnt + 1, T_RAS_REF);
          if (ref_cnt > 0)
            chk((cyc - last_ref_cyc >= REF_PERIOD - SLACK) &&
                (cyc - last_ref_cyc <= REF_PERIOD + SLACK),
                "R8 refresh interval", cyc - last_ref_cyc, REF_PERIOD);
          exp_ref_row = exp_ref_row + 1'b1;
          last_ref_cyc = cyc;
          ref_cnt++;
        end
      end else if (dram_ras_n) hi_cnt++;
      if (prev_cas && !dram_cas_n) begin
        chk(dram_ma == prev_ma, "R2 column stable at CAS fall", dram_ma, prev_ma);
        chk((dram_we_n == prev_we) && (dram_din == prev_din), "R3 early write setup",
            {dram_we_n, dram_din}, {prev_we, prev_din});
        chk(!dram_ras_n, "R2 CAS inside RAS", dram_ras_n, 0);
        if (!had_cas)
          chk(lo_cnt >= T_RCD && lo_cnt >= T_RAH, "R2 RAS to CAS delay", lo_cnt, T_RCD);
        had_cas  = 1;
        last_key = {open_row, dram_ma};
        last_wr  = !dram_we_n;
        if (!dram_we_n) mem[int'({open_row, dram_ma})] = dram_din;
      end
      prev_ras = dram_ras_n; prev_cas = dram_cas_n;
      prev_we  = dram_we_n;  prev_din = dram_din; prev_ma = dram_ma;
    end
  end

  // ---------------- host access ----------------
  int ref_waits = 0;

  task automatic access(input logic [15:0] a, input logic w, input logic d,
                        output logic q, output int opens);
    int rf0, rr0, cas_cycles;
    rf0 = ras_falls; rr0 = ref_cnt;
    cas_cycles = 0;
    @(negedge clk);
    host_req = 1'b1; host_we = w; host_addr = a; host_wdata = d;
    do begin
      @(negedge clk);
      if (!dram_cas_n) cas_cycles++;
    end while (!host_done);
    q = host_rdata;
    host_req = 1'b0;
    opens = (ras_falls - rf0) - (ref_cnt - rr0);
    if (ref_cnt != rr0) ref_waits++;
    chk(last_key == a, "R1 address split", last_key, a);
    chk(last_wr == w, "R3 direction on WE", last_wr, w);
    chk(cas_cycles == T_CAS, "R4 CAS low length", cas_cycles, T_CAS);
    @(negedge clk);
    chk(!host_done, "R5 done is one cycle", host_done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic q;
    int op;
    int burst_rf, burst_rr;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !host_done, "R11 reset outputs",
        {dram_ras_n, dram_cas_n, dram_we_n, host_done}, 4'b1110);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n && !host_done, "R11 after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, host_done}, 4'b1110);

    // write two columns of every row: first opens the row, second hits it
    for (int r = 0; r < 256; r++) begin
      logic [15:0] a0, a1;
      a0 = {8'(r), 8'(r) ^ 8'h5A};
      a1 = {8'(r), ~8'(r)};
      access(a0, 1'b1, pat(a0, 16'h1234), q, op);
      chk(op == 1, "R7 row miss opens row", op, 1);
      burst_rr = ref_cnt;
      access(a1, 1'b1, pat(a1, 16'h1234), q, op);
      chk(op == ((ref_cnt != burst_rr) ? 1 : 0), "R6 page hit keeps RAS low", op,
          (ref_cnt != burst_rr) ? 1 : 0);
    end
    // read them back
    for (int r = 0; r < 256; r++) begin
      logic [15:0] a0, a1;
      a0 = {8'(r), 8'(r) ^ 8'h5A};
      a1 = {8'(r), ~8'(r)};
      access(a0, 1'b0, 1'b0, q, op);
      chk(q == pat(a0, 16'h1234), "R4 read data", q, pat(a0, 16'h1234));
      access(a1, 1'b0, 1'b1, q, op);
      chk(q == pat(a1, 16'h1234), "R4 read data page hit", q, pat(a1, 16'h1234));
    end
    // full-row burst in page mode
    burst_rf = ras_falls; burst_rr = ref_cnt;
    for (int c = 0; c < 256; c++)
      access({8'hC3, 8'(c)}, 1'b1, pat({8'hC3, 8'(c)}, 16'h0F0F), q, op);
    for (int c = 0; c < 256; c++) begin
      access({8'hC3, 8'(c)}, 1'b0, 1'b0, q, op);
      chk(q == pat({8'hC3, 8'(c)}, 16'h0F0F), "R6 burst read data", q,
          pat({8'hC3, 8'(c)}, 16'h0F0F));
    end
    op = (ras_falls - burst_rf) - (ref_cnt - burst_rr);
    chk(op == 1 + (ref_cnt - burst_rr), "R6 burst row opens", op, 1 + (ref_cnt - burst_rr));
    chk(ref_cnt >= 128, "R9 all 128 rows refreshed", ref_cnt, 128);
    chk(ref_waits > 0, "R10 requests completed across refresh", ref_waits, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule